// File: doc/BRIEF.md
# Virtual-to-Physical Translator with Resident Page Map

The block turns a byte-granular virtual address into a physical address. Its first stage is a four-entry associative lookaside cache, in which every entry is compared with the request at once. When that cache misses, the block reads an on-chip page map that holds a resident bit and a physical page number for each virtual page. When the page map holds a valid mapping, the block copies it into the cache and answers. When the page is not resident, the block hands out a new physical page, records it in the page map, fills the cache and answers.

Each answer carries the physical address, a two-bit outcome code and an error flag. The code tells the requester which of the three routes was taken. Requests and answers each use a valid/ready handshake, and only one request is in flight at a time. After reset, both the lookaside cache and the page map hold a fixed starting mapping. Some pages in that mapping are resident and some are not.

Top module: `vmx_translate`

## Requirements
- R1: Pages are 8192 bytes. The low 13 bits of the physical address equal the low 13 bits of the virtual address, and the physical page number occupies the bits above them.
- R2: A request whose virtual page number (VPN) matches a valid cache entry answers with outcome code 2'b00 and that entry's page number. The answer appears in the cycle after acceptance.
- R3: A cache miss on a resident page answers with code 2'b01 and the page map's page number two cycles after acceptance. It also writes that mapping into a cache entry, so the next request to the same page is a hit.
- R4: A cache miss on a non-resident page answers with code 2'b10 three cycles after acceptance. The new page number is one greater than the largest page number assigned since reset. The page map then holds that mapping as resident, and the cache is filled with it.
- R5: When the cache is full, a fill replaces the least recently used entry. Both a hit and a fill make the touched entry the most recently used.
- R6: An invalid cache entry is always chosen for a fill before any valid entry is replaced.
- R7: After reset, the page map holds these resident pages (VPN to page): 0 to 5, 3 to 6, 4 to 9, 5 to 11, 7 to 4, 10 to 3 and 11 to 12. VPNs 1, 2, 6, 8 and 9 are not resident. The next page number handed out after reset is 13.
- R8: After reset, cache entries 0, 1 and 2 hold valid mappings 11 to 12, 7 to 4 and 3 to 6. Entry 3 is invalid. The recency order runs from entry 0 (oldest) to entry 3 (newest).
- R9: A VPN of 16 or more (at or beyond the page map depth) answers one cycle after acceptance with the error flag set, code 2'b11 and address 0. It changes no cache entry, no recency order and no page allocation.
- R10: The request side is ready only when no request is in flight. While an answer is offered and not taken, the address, code and error flag stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | A translation request is offered |
| req_ready | output | 1 | The block accepts a request in this cycle |
| req_va | input | VA_W (32) | Byte virtual address |
| rsp_valid | output | 1 | An answer is offered |
| rsp_ready | input | 1 | The requester takes the answer |
| rsp_pa | output | PA_W (21) | Translated physical address |
| rsp_kind | output | 2 | Outcome: 00 cache hit, 01 page-map hit, 10 new page, 11 error |
| rsp_err | output | 1 | The VPN lies outside the page map |

## Verification
The assertions check invariants on every cycle:
- No two valid cache entries share a VPN.
- Exactly one entry is the oldest, and a touched entry becomes the newest.
- An allocation raises the page-number ceiling by exactly one and only ever targets a non-resident page.
- An out-of-range request reaches the answer stage at once.
- A stalled answer holds still, and the request side stays closed while an answer is pending.

Some behaviour only the bench scenarios can show:
- The actual page numbers and addresses.
- The exact latency of each route.
- Which entry a replacement evicts, observed as a later page-map hit on a VPN that used to hit.
- The contents restored by a second reset.
- That an error request leaves the next allocated page number unchanged.

// File: rtl/vmx_pkg.sv
package vmx_pkg;

  typedef enum logic [1:0] {
    KIND_TLB   = 2'b00,
    KIND_MAP   = 2'b01,
    KIND_NEW   = 2'b10,
    KIND_ERR   = 2'b11
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WALK  = 2'd1,
    ST_ALLOC = 2'd2,
    ST_RESP  = 2'd3
  } state_e;

  // Reset image of the page map: resident flag per VPN.
  function automatic bit map_init_valid(int vpn);
    case (vpn)
      0, 3, 4, 5, 7, 10, 11: return 1'b1;
      default:               return 1'b0;
    endcase
  endfunction

  // Reset image of the page map: physical page per VPN.
  function automatic int map_init_page(int vpn);
    case (vpn)
      0:       return 5;
      3:       return 6;
      4:       return 9;
      5:       return 11;
      7:       return 4;
      10:      return 3;
      11:      return 12;
      default: return 0;
    endcase
  endfunction

  // Largest page number present in the reset page map.
  function automatic int map_init_ceiling(int depth);
    int top;
    top = 0;
    for (int v = 0; v < depth; v++) begin
      if (map_init_valid(v) && map_init_page(v) > top) top = map_init_page(v);
    end
    return top;
  endfunction

  // Reset image of the lookaside cache.
  function automatic bit cache_init_valid(int slot);
    return (slot < 3);
  endfunction

  function automatic int cache_init_tag(int slot);
    case (slot)
      0:       return 11;
      1:       return 7;
      2:       return 3;
      3:       return 4;
      default: return 0;
    endcase
  endfunction

  function automatic int cache_init_page(int slot);
    case (slot)
      0:       return 12;
      1:       return 4;
      2:       return 6;
      3:       return 9;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/vmx_recency.sv
module vmx_recency #(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [N-1:0]     slot_valid,
  output logic [IDX_W-1:0] victim_idx
);

  localparam int AGE_W = $clog2(N);
  localparam logic [AGE_W-1:0] AGE_OLD = AGE_W'(N - 1);

  logic [AGE_W-1:0] age_q [N];
  logic [AGE_W-1:0] age_d [N];
  logic [N-1:0]     is_old;

  always_comb begin
    for (int i = 0; i < N; i++) age_d[i] = age_q[i];
    if (touch_en) begin
      for (int i = 0; i < N; i++) begin
        if (age_q[i] < age_q[touch_idx]) age_d[i] = age_q[i] + 1'b1;
      end
      age_d[touch_idx] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= AGE_W'(N - 1 - i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) age_q[i] <= age_d[i];
    end
  end

  generate
    for (genvar g = 0; g < N; g++) begin : g_old
      assign is_old[g] = (age_q[g] == AGE_OLD);
    end
  endgenerate

  // Invalid slots win over the oldest valid slot.
  always_comb begin
    logic found;
    found      = 1'b0;
    victim_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (!found && !slot_valid[i]) begin
        victim_idx = IDX_W'(i);
        found      = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < N; i++) begin
        if (is_old[i]) victim_idx = IDX_W'(i);
      end
    end
  end

  a_r5_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(is_old) == 1);

  a_r5_touch_is_newest: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> age_q[$past(touch_idx)] == '0);

endmodule

// File: rtl/vmx_cache.sv
module vmx_cache #(
  parameter int N     = 4,
  parameter int VPN_W = 19,
  parameter int PPN_W = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             look_hit,
  output logic [IDX_W-1:0] look_idx,
  output logic [PPN_W-1:0] look_ppn,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  output logic [N-1:0]     slot_valid
);

  import vmx_pkg::*;

  logic             valid_q [N];
  logic [VPN_W-1:0] tag_q   [N];
  logic [PPN_W-1:0] ppn_q   [N];
  logic             valid_d [N];
  logic [VPN_W-1:0] tag_d   [N];
  logic [PPN_W-1:0] ppn_d   [N];
  logic [N-1:0]     match;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      valid_d[i] = valid_q[i];
      tag_d[i]   = tag_q[i];
      ppn_d[i]   = ppn_q[i];
    end
    if (fill_en) begin
      valid_d[fill_idx] = 1'b1;
      tag_d[fill_idx]   = fill_vpn;
      ppn_d[fill_idx]   = fill_ppn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        valid_q[i] <= cache_init_valid(i);
        tag_q[i]   <= VPN_W'(cache_init_tag(i));
        ppn_q[i]   <= PPN_W'(cache_init_page(i));
      end
    end else if (fill_en) begin
      for (int i = 0; i < N; i++) begin
        valid_q[i] <= valid_d[i];
        tag_q[i]   <= tag_d[i];
        ppn_q[i]   <= ppn_d[i];
      end
    end
  end

  generate
    for (genvar g = 0; g < N; g++) begin : g_cmp
      assign match[g]      = valid_q[g] && (tag_q[g] == look_vpn);
      assign slot_valid[g] = valid_q[g];
    end
  endgenerate

  always_comb begin
    look_idx = '0;
    look_ppn = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) begin
        look_idx = IDX_W'(i);
        look_ppn = ppn_q[i];
      end
    end
  end

  assign look_hit = |match;

  a_r3_no_duplicate_tags: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  a_r3_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> valid_q[$past(fill_idx)] && tag_q[$past(fill_idx)] == $past(fill_vpn)
                && ppn_q[$past(fill_idx)] == $past(fill_ppn));

endmodule

// File: rtl/vmx_pagemap.sv
module vmx_pagemap #(
  parameter int DEPTH = 16,
  parameter int PPN_W = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [PPN_W-1:0] rd_ppn,
  input  logic             alloc_en,
  output logic [PPN_W-1:0] alloc_ppn
);

  import vmx_pkg::*;

  localparam logic [PPN_W-1:0] CEIL_RST = PPN_W'(map_init_ceiling(DEPTH));

  logic             valid_q [DEPTH];
  logic [PPN_W-1:0] ppn_q   [DEPTH];
  logic [PPN_W-1:0] ceil_q;
  logic [PPN_W-1:0] ceil_d;

  assign rd_valid  = valid_q[rd_idx];
  assign rd_ppn    = ppn_q[rd_idx];
  assign ceil_d    = ceil_q + 1'b1;
  assign alloc_ppn = ceil_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        valid_q[i] <= map_init_valid(i);
        ppn_q[i]   <= PPN_W'(map_init_page(i));
      end
      ceil_q <= CEIL_RST;
    end else if (alloc_en) begin
      valid_q[rd_idx] <= 1'b1;
      ppn_q[rd_idx]   <= ceil_d;
      ceil_q          <= ceil_d;
    end
  end

  a_r4_ceiling_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> ceil_q == $past(ceil_q) + 1'b1);

  a_r4_alloc_only_absent: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !rd_valid);

  a_r4_alloc_marks_resident: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> valid_q[$past(rd_idx)] && ppn_q[$past(rd_idx)] == ceil_q);

endmodule

// File: rtl/vmx_translate.sv
module vmx_translate #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 13,
  parameter int PPN_W     = 8,
  parameter int MAP_DEPTH = 16,
  parameter int TLB_N     = 4,
  parameter int PA_W      = PPN_W + PAGE_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_va,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [PA_W-1:0] rsp_pa,
  output logic [1:0]      rsp_kind,
  output logic            rsp_err
);

  import vmx_pkg::*;

  localparam int VPN_W  = VA_W - PAGE_BITS;
  localparam int MIDX_W = $clog2(MAP_DEPTH);
  localparam int TIDX_W = $clog2(TLB_N);
  localparam logic [VPN_W:0] MAP_LIMIT = (VPN_W + 1)'(MAP_DEPTH);

  // Reset: asserted at once, released after two clocks.
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [VPN_W-1:0]     req_vpn;
  logic [PAGE_BITS-1:0] req_off;
  logic                 in_range;
  logic                 accept;

  assign req_vpn  = req_va[VA_W-1:PAGE_BITS];
  assign req_off  = req_va[PAGE_BITS-1:0];
  assign in_range = {1'b0, req_vpn} < MAP_LIMIT;

  state_e               state_q, state_d;
  logic [VPN_W-1:0]     vpn_q;
  logic [PAGE_BITS-1:0] off_q;
  logic                 hold_load;
  logic [PA_W-1:0]      pa_q, pa_d;
  logic [1:0]           kind_q, kind_d;
  logic                 err_q, err_d;
  logic                 out_load;

  logic              look_hit;
  logic [TIDX_W-1:0] look_idx;
  logic [PPN_W-1:0]  look_ppn;
  logic              fill_en;
  logic [PPN_W-1:0]  fill_ppn;
  logic [TLB_N-1:0]  slot_valid;
  logic [TIDX_W-1:0] victim_idx;
  logic              touch_en;
  logic [TIDX_W-1:0] touch_idx;
  logic              map_valid;
  logic [PPN_W-1:0]  map_ppn;
  logic              alloc_en;
  logic [PPN_W-1:0]  alloc_ppn;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  vmx_cache #(
    .N     (TLB_N),
    .VPN_W (VPN_W),
    .PPN_W (PPN_W),
    .IDX_W (TIDX_W)
  ) u_cache (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .look_vpn   (req_vpn),
    .look_hit   (look_hit),
    .look_idx   (look_idx),
    .look_ppn   (look_ppn),
    .fill_en    (fill_en),
    .fill_idx   (victim_idx),
    .fill_vpn   (vpn_q),
    .fill_ppn   (fill_ppn),
    .slot_valid (slot_valid)
  );

  vmx_recency #(
    .N     (TLB_N),
    .IDX_W (TIDX_W)
  ) u_recency (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .touch_en   (touch_en),
    .touch_idx  (touch_idx),
    .slot_valid (slot_valid),
    .victim_idx (victim_idx)
  );

  vmx_pagemap #(
    .DEPTH (MAP_DEPTH),
    .PPN_W (PPN_W),
    .IDX_W (MIDX_W)
  ) u_pagemap (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .rd_idx    (vpn_q[MIDX_W-1:0]),
    .rd_valid  (map_valid),
    .rd_ppn    (map_ppn),
    .alloc_en  (alloc_en),
    .alloc_ppn (alloc_ppn)
  );

  // Next-state and datapath control.
  always_comb begin
    state_d   = state_q;
    hold_load = 1'b0;
    out_load  = 1'b0;
    pa_d      = pa_q;
    kind_d    = kind_q;
    err_d     = err_q;
    fill_en   = 1'b0;
    fill_ppn  = map_ppn;
    touch_en  = 1'b0;
    touch_idx = victim_idx;
    alloc_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (!in_range) begin
            out_load = 1'b1;
            pa_d     = '0;
            kind_d   = KIND_ERR;
            err_d    = 1'b1;
            state_d  = ST_RESP;
          end else if (look_hit) begin
            out_load  = 1'b1;
            pa_d      = {look_ppn, req_off};
            kind_d    = KIND_TLB;
            err_d     = 1'b0;
            touch_en  = 1'b1;
            touch_idx = look_idx;
            state_d   = ST_RESP;
          end else begin
            hold_load = 1'b1;
            state_d   = ST_WALK;
          end
        end
      end
      ST_WALK: begin
        if (map_valid) begin
          fill_en  = 1'b1;
          touch_en = 1'b1;
          out_load = 1'b1;
          pa_d     = {map_ppn, off_q};
          kind_d   = KIND_MAP;
          err_d    = 1'b0;
          state_d  = ST_RESP;
        end else begin
          state_d = ST_ALLOC;
        end
      end
      ST_ALLOC: begin
        alloc_en = 1'b1;
        fill_en  = 1'b1;
        fill_ppn = alloc_ppn;
        touch_en = 1'b1;
        out_load = 1'b1;
        pa_d     = {alloc_ppn, off_q};
        kind_d   = KIND_NEW;
        err_d    = 1'b0;
        state_d  = ST_RESP;
      end
      ST_RESP: begin
        if (rsp_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      vpn_q <= '0;
      off_q <= '0;
    end else if (hold_load) begin
      vpn_q <= req_vpn;
      off_q <= req_off;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      pa_q   <= '0;
      kind_q <= KIND_TLB;
      err_q  <= 1'b0;
    end else if (out_load) begin
      pa_q   <= pa_d;
      kind_q <= kind_d;
      err_q  <= err_d;
    end
  end

  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_pa    = pa_q;
  assign rsp_kind  = kind_q;
  assign rsp_err   = err_q;

  a_r10_answer_holds: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_pa)
                                  && $stable(rsp_kind) && $stable(rsp_err));

  a_r10_closed_while_pending: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_valid |-> !req_ready);

  a_r9_error_answers_next: assert property (@(posedge clk) disable iff (!rst_n_s)
    (accept && !in_range) |=> rsp_valid && rsp_err && rsp_kind == KIND_ERR);

  a_r9_error_touches_nothing: assert property (@(posedge clk) disable iff (!rst_n_s)
    (accept && !in_range) |-> !fill_en && !touch_en && !alloc_en);

  a_r2_hit_answers_next: assert property (@(posedge clk) disable iff (!rst_n_s)
    (accept && in_range && look_hit) |=> rsp_valid && rsp_kind == KIND_TLB);

endmodule

// File: tb/vmx_translate_test.sv
module vmx_translate_test;

  localparam int VA_W = 32;
  localparam int PA_W = 21;
  localparam int PG   = 8192;

  logic            clk;
  logic            rst_n;
  logic            req_valid;
  logic            req_ready;
  logic [VA_W-1:0] req_va;
  logic            rsp_valid;
  logic            rsp_ready;
  logic [PA_W-1:0] rsp_pa;
  logic [1:0]      rsp_kind;
  logic            rsp_err;

  int checks;
  int errors;
  int cycles;
  bit done;

  vmx_translate uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_va    (req_va),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_pa    (rsp_pa),
    .rsp_kind  (rsp_kind),
    .rsp_err   (rsp_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply_reset();
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_va    = '0;
    rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Issue one request and check latency, code, error flag and address.
  task automatic xlate(input int va, input int exp_ppn, input int exp_kind,
                       input int exp_lat, input string req);
    int lat;
    int exp_pa;
    bit exp_err;
    exp_err = (exp_kind == 3);
    exp_pa  = exp_err ? 0 : exp_ppn * PG + (va % PG);
    chk(req_ready == 1'b1, req, "ready before request", int'(req_ready), 1);
    req_va    = VA_W'(va);
    req_valid = 1'b1;
    lat       = 0;
    do begin
      @(negedge clk);
      req_valid = 1'b0;
      lat++;
    end while (!rsp_valid && lat < 20);
    chk(lat == exp_lat, req, "latency", lat, exp_lat);
    chk(int'(rsp_kind) == exp_kind, req, "outcome code", int'(rsp_kind), exp_kind);
    chk(int'(rsp_pa) == exp_pa, req, "physical address", int'(rsp_pa), exp_pa);
    chk(rsp_err == exp_err, req, "error flag", int'(rsp_err), int'(exp_err));
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk(req_ready == 1'b1, "R10", "ready after reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R10", "no answer after reset", int'(rsp_valid), 0);
  endtask

  // Reference address stream from reset; R6 on first fill, R5 evictions.
  task automatic t_stream();
    xlate(4669,  5,  1, 2, "R3_R6");   // VPN0 fills invalid slot 3
    xlate(2227,  5,  0, 1, "R2");      // VPN0 now hits
    xlate(13916, 13, 2, 3, "R4");      // VPN1 new page 13, evicts slot 0
    xlate(34587, 9,  1, 2, "R3_R5");   // VPN4 evicts slot 1
    xlate(48870, 11, 1, 2, "R3_R5");   // VPN5 evicts slot 2
    xlate(12608, 13, 0, 1, "R2_R1");   // VPN1 hits with offset 4416
    xlate(49225, 14, 2, 3, "R4_R5");   // VPN6 new page 14, evicts slot 3
  endtask

  // VPN0 lost its slot in the last step: back through the page map.
  task automatic t_evicted();
    xlate(3 * 1, 5, 1, 2, "R5");
    xlate(100, 5, 0, 1, "R5");
  endtask

  task automatic t_range_error();
    xlate(16 * PG + 7, 0, 3, 1, "R9");
    xlate(200 * PG, 0, 3, 1, "R9");
    xlate(2 * PG + 9, 15, 2, 3, "R9_R4"); // ceiling not moved by the errors
    xlate(2 * PG + 10, 15, 0, 1, "R3");   // new page now in cache
  endtask

  task automatic t_backpressure();
    int pa0;
    rsp_ready = 1'b0;
    req_va    = VA_W'(6 * PG + 100);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R10", "answer offered", int'(rsp_valid), 1);
    pa0 = int'(rsp_pa);
    chk(pa0 == 14 * PG + 100, "R10", "stalled address", pa0, 14 * PG + 100);
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b1, "R10", "answer still offered", int'(rsp_valid), 1);
    chk(int'(rsp_pa) == pa0, "R10", "address held", int'(rsp_pa), pa0);
    chk(req_ready == 1'b0, "R10", "request side closed", int'(req_ready), 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10", "answer taken", int'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R10", "request side reopened", int'(req_ready), 1);
  endtask

  // A second reset restores the starting image.
  task automatic t_reset_image();
    apply_reset();
    xlate(11 * PG + 1, 12, 0, 1, "R8");
    xlate(7 * PG + 2,  4,  0, 1, "R8");
    xlate(3 * PG + 3,  6,  0, 1, "R8");
    xlate(4 * PG + 4,  9,  1, 2, "R8_R6"); // slot 3 was invalid
    xlate(10 * PG + 5, 3,  1, 2, "R7_R5"); // evicts slot 0 (VPN11)
    xlate(11 * PG + 6, 12, 1, 2, "R7_R5");
    xlate(8 * PG + 8,  13, 2, 3, "R7_R4"); // first new page after reset
    xlate(9 * PG + 9,  14, 2, 3, "R4");
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    apply_reset();
    t_reset_state();
    t_stream();
    t_evicted();
    t_range_error();
    t_backpressure();
    t_reset_image();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule